// File: doc/BRIEF.md
# Multi-mode encoder position counter

This block keeps a position count of up to four bytes for an incremental encoder. A decoder placed in front of it delivers one-clock count pulses with a direction bit and a qualified index strobe. The count can run free, stop after its first overflow or underflow, stay between zero and a preset limit, or cycle modulo a preset value. The active counter width can be narrowed to one, two or three bytes at run time.

A preset register supplies load values, limits and the compare value. A snapshot register captures the count on request. A status byte latches carry, borrow, compare and index events. Two active-low flags report these events to the host. One is sticky and filtered by per-event enables. The other is a one-clock marker whose sources depend on the counting mode.

Software strobes load, clear or snapshot the counter. The index strobe can be set to do any one of these. Configuration is written through two small registers that share one write-data bus.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the count, preset and snapshot read zero. The status byte holds only the power-loss bit (bit 2). Both flags are high. Both configuration registers are zero, which selects free-running counting at the full four-byte width.
- R2: A count event takes effect only when `cnt_pulse` and `cnt_enable` are both high and the count-disable bit (config B bit 2) is 0. Otherwise the count holds. Status bit 3 shows `cnt_enable` AND NOT the disable bit.
- R3: The width field (config B bits 1:0) selects the active width: 00 gives 4 bytes, 01 gives 3, 10 gives 2 and 11 gives 1. The count, preset and snapshot outputs are masked to that width, and carry and borrow are taken at that width.
- R4: The counting mode is set by config A bits 1:0. In free-running mode (00), counting up from all-ones gives 0 and raises carry. Counting down from 0 gives all-ones and raises borrow.
- R5: In single-cycle mode (01), the count wraps and raises carry or borrow as in free-running mode. It then ignores count pulses until a clear or a load.
- R6: In range-limit mode (10), an up pulse at the preset value leaves the count unchanged and raises carry. A down pulse at zero leaves the count unchanged and raises borrow. Otherwise the count moves by one in the pulse direction.
- R7: In modulo-n mode (11), with n the masked preset, counting up from n gives 0 and raises carry. Counting down from 0 gives n and raises borrow.
- R8: Config A bits 3:2 select what an index strobe does: 00 nothing, 01 load the count from the preset, 10 clear the count, 11 copy the count into the snapshot register.
- R9: Software strobes have a fixed priority: clear wins over load, and load wins over a count pulse in the same cycle. A snapshot captures the count held before that cycle's update.
- R10: The status byte is laid out from bit 7 down to bit 0 as: carry, borrow, compare, index, enable state, power loss, direction (1 = up) and sign. Compare means a count event left the count equal to the masked preset. The sign bit toggles on every carry or borrow. The direction bit records the direction of the last count event. `stat_clear` zeroes the stored bits, but an event in the same cycle still sets its bit.
- R11: Config B bits 7:4 enable the latched flag for carry (bit 7), borrow (6), compare (5) and index (4). `lflag_n` is low while any enabled latch in the status byte is set.
- R12: `dflag_n` goes low for one clock, in the same clock edge as the count update that caused it. The sources depend on the counting mode: free-running uses the enabled events; single-cycle uses carry or borrow; range-limit and modulo-n use compare while counting up, or borrow, whatever the enables are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pulse | input | 1 | One-clock count request from the decoder |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_enable | input | 1 | External count enable |
| index_stb | input | 1 | Qualified index strobe |
| sw_clear | input | 1 | Clear the counter |
| sw_load | input | 1 | Load the counter from the preset |
| sw_snap | input | 1 | Copy the counter into the snapshot register |
| stat_clear | input | 1 | Clear the status latches |
| cfg_a_wr | input | 1 | Write config A (mode, index action) from `cfg_wdata[3:0]` |
| cfg_b_wr | input | 1 | Write config B (width, disable, flag enables) from `cfg_wdata` |
| cfg_wdata | input | 8 | Configuration write data |
| preset_wr | input | 1 | Write the preset register |
| preset_wdata | input | 8*BYTES | Preset write data |
| count_q | output | 8*BYTES | Counter value, masked to the active width |
| snap_q | output | 8*BYTES | Snapshot value, masked to the active width |
| preset_q | output | 8*BYTES | Preset value, masked to the active width |
| status_q | output | 8 | Status byte |
| lflag_n | output | 1 | Latched event flag, active low |
| dflag_n | output | 1 | Dynamic event marker, active low |

## Verification
The embedded assertions check properties that must hold on every cycle:
- the count holds while counting is disabled or while single-cycle mode is stopped;
- range-limit mode freezes at its upper limit;
- modulo-n mode wraps to zero after n;
- the latched flag stays low until a status clear or a change of the enables;
- the dynamic marker is never low without a matching status latch.

Only the bench scenarios can show the exact count sequences at each width and in each mode. The same holds for the index actions, the priority of the strobes, and the cycle in which each status bit and flag changes.

// File: rtl/enc_cnt_pkg.sv
package enc_cnt_pkg;

   typedef enum logic [1:0] {
      CM_FREE   = 2'b00,
      CM_SINGLE = 2'b01,
      CM_RANGE  = 2'b10,
      CM_MODN   = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      IX_NONE  = 2'b00,
      IX_LOAD  = 2'b01,
      IX_CLEAR = 2'b10,
      IX_SNAP  = 2'b11
   } idx_act_e;

   localparam int CFG_A_W = 4;
   localparam int FLAG_SRC_W = 4;

endpackage

// File: rtl/enc_cnt_mask.sv
module enc_cnt_mask #(
   parameter  int BYTES = 4,
   localparam int W     = 8 * BYTES
) (
   input  logic [1:0]   wsel,
   output logic [W-1:0] mask
);

   int nb;

   always_comb begin
      if (int'(wsel) >= BYTES) nb = 1;
      else                     nb = BYTES - int'(wsel);
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign mask[8*b +: 8] = (b < nb) ? 8'hFF : 8'h00;
   end

endmodule

// File: rtl/enc_cnt_step.sv
module enc_cnt_step
   import enc_cnt_pkg::*;
#(
   parameter int W = 32
) (
   input  cnt_mode_e    mode,
   input  logic         up,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] lim,
   input  logic [W-1:0] mask,
   output logic [W-1:0] nxt,
   output logic         cy,
   output logic         bw
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] inc;
   logic [W-1:0] dec;

   assign inc = (cnt + ONE) & mask;
   assign dec = (cnt - ONE) & mask;

   always_comb begin
      cy  = 1'b0;
      bw  = 1'b0;
      nxt = cnt;
      unique case (mode)
         CM_RANGE: begin
            if (up) begin
               if (cnt == lim) cy  = 1'b1;
               else            nxt = inc;
            end else begin
               if (cnt == '0)  bw  = 1'b1;
               else            nxt = dec;
            end
         end
         CM_MODN: begin
            if (up) begin
               if (cnt == lim) begin nxt = '0; cy = 1'b1; end
               else            nxt = inc;
            end else begin
               if (cnt == '0)  begin nxt = lim; bw = 1'b1; end
               else            nxt = dec;
            end
         end
         default: begin
            if (up) begin
               if (cnt == mask) begin nxt = '0; cy = 1'b1; end
               else             nxt = inc;
            end else begin
               if (cnt == '0)   begin nxt = mask; bw = 1'b1; end
               else             nxt = dec;
            end
         end
      endcase
   end

endmodule

// File: rtl/enc_cnt_flags.sv
module enc_cnt_flags
   import enc_cnt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  cnt_mode_e             mode,
   input  logic                  ev,
   input  logic                  up,
   input  logic                  cy,
   input  logic                  bw,
   input  logic                  cmp,
   input  logic                  idx,
   input  logic                  sclr,
   input  logic                  en_state,
   input  logic [FLAG_SRC_W-1:0] fmask,
   output logic [7:0]            status,
   output logic                  lflag_n,
   output logic                  dflag_n
);

   logic l_cy, l_bw, l_cmp, l_idx, l_pls, l_dir, l_sgn;
   logic dyn_hit;

   always_comb begin
      unique case (mode)
         CM_FREE:   dyn_hit = |({cy, bw, cmp, idx} & fmask);
         CM_SINGLE: dyn_hit = cy | bw;
         default:   dyn_hit = (cmp & up) | bw;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_cy    <= 1'b0;
         l_bw    <= 1'b0;
         l_cmp   <= 1'b0;
         l_idx   <= 1'b0;
         l_pls   <= 1'b1;
         l_dir   <= 1'b0;
         l_sgn   <= 1'b0;
         dflag_n <= 1'b1;
      end else begin
         l_cy    <= (l_cy  & ~sclr) | cy;
         l_bw    <= (l_bw  & ~sclr) | bw;
         l_cmp   <= (l_cmp & ~sclr) | cmp;
         l_idx   <= (l_idx & ~sclr) | idx;
         l_pls   <= l_pls & ~sclr;
         l_dir   <= ev ? up : (l_dir & ~sclr);
         l_sgn   <= (l_sgn & ~sclr) ^ (cy | bw);
         dflag_n <= ~dyn_hit;
      end
   end

   assign status  = {l_cy, l_bw, l_cmp, l_idx, en_state, l_pls, l_dir, l_sgn};
   assign lflag_n = ~|({l_cy, l_bw, l_cmp, l_idx} & fmask);

   AST_LFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!lflag_n && !sclr) |=> (!lflag_n || !$stable(fmask)));  // R11

   AST_DFLAG_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !dflag_n |-> (status[7:4] != 4'b0000));  // R12

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
   import enc_cnt_pkg::*;
#(
   parameter  int BYTES = 4,
   localparam int W     = 8 * BYTES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_pulse,
   input  logic         cnt_up,
   input  logic         cnt_enable,
   input  logic         index_stb,
   input  logic         sw_clear,
   input  logic         sw_load,
   input  logic         sw_snap,
   input  logic         stat_clear,
   input  logic         cfg_a_wr,
   input  logic         cfg_b_wr,
   input  logic [7:0]   cfg_wdata,
   input  logic         preset_wr,
   input  logic [W-1:0] preset_wdata,
   output logic [W-1:0] count_q,
   output logic [W-1:0] snap_q,
   output logic [W-1:0] preset_q,
   output logic [7:0]   status_q,
   output logic         lflag_n,
   output logic         dflag_n
);

   if (BYTES < 1 || BYTES > 4) begin : g_bad_bytes
      $error("enc_pos_counter: BYTES must lie in 1..4");
   end

   logic [CFG_A_W-1:0]    cfg_a;
   logic [1:0]            wsel_r;
   logic                  dis_r;
   logic [FLAG_SRC_W-1:0] fmask_r;
   logic [W-1:0]          preset_r;
   logic [W-1:0]          cnt_r;
   logic [W-1:0]          snap_r;
   logic                  stop_r;

   cnt_mode_e    mode;
   idx_act_e     iact;
   logic [W-1:0] mask;
   logic [W-1:0] lim;
   logic [W-1:0] cnt_m;
   logic [W-1:0] nxt;
   logic         cy_raw, bw_raw;
   logic         do_clr, do_ld, do_snap;
   logic         run, ev, ev_cy, ev_bw, ev_cmp;

   assign mode = cnt_mode_e'(cfg_a[1:0]);
   assign iact = idx_act_e'(cfg_a[3:2]);

   enc_cnt_mask #(.BYTES(BYTES)) i_mask (
      .wsel (wsel_r),
      .mask (mask)
   );

   assign lim   = preset_r & mask;
   assign cnt_m = cnt_r & mask;

   enc_cnt_step #(.W(W)) i_step (
      .mode (mode),
      .up   (cnt_up),
      .cnt  (cnt_m),
      .lim  (lim),
      .mask (mask),
      .nxt  (nxt),
      .cy   (cy_raw),
      .bw   (bw_raw)
   );

   assign do_clr  = sw_clear | (index_stb & (iact == IX_CLEAR));
   assign do_ld   = ~do_clr & (sw_load | (index_stb & (iact == IX_LOAD)));
   assign do_snap = sw_snap | (index_stb & (iact == IX_SNAP));

   assign run    = cnt_enable & ~dis_r & ~((mode == CM_SINGLE) & stop_r);
   assign ev     = cnt_pulse & run & ~do_clr & ~do_ld;
   assign ev_cy  = ev & cy_raw;
   assign ev_bw  = ev & bw_raw;
   assign ev_cmp = ev & (nxt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_a    <= '0;
         wsel_r   <= '0;
         dis_r    <= 1'b0;
         fmask_r  <= '0;
         preset_r <= '0;
      end else begin
         if (cfg_a_wr) cfg_a <= cfg_wdata[CFG_A_W-1:0];
         if (cfg_b_wr) begin
            wsel_r  <= cfg_wdata[1:0];
            dis_r   <= cfg_wdata[2];
            fmask_r <= cfg_wdata[7:4];
         end
         if (preset_wr) preset_r <= preset_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_r  <= '0;
         snap_r <= '0;
         stop_r <= 1'b0;
      end else begin
         if (do_clr)     cnt_r <= '0;
         else if (do_ld) cnt_r <= lim;
         else if (ev)    cnt_r <= nxt;

         if (do_clr || do_ld)
            stop_r <= 1'b0;
         else if ((mode == CM_SINGLE) && (ev_cy || ev_bw))
            stop_r <= 1'b1;

         if (do_snap) snap_r <= cnt_m;
      end
   end

   enc_cnt_flags i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .ev       (ev),
      .up       (cnt_up),
      .cy       (ev_cy),
      .bw       (ev_bw),
      .cmp      (ev_cmp),
      .idx      (index_stb),
      .sclr     (stat_clear),
      .en_state (cnt_enable & ~dis_r),
      .fmask    (fmask_r),
      .status   (status_q),
      .lflag_n  (lflag_n),
      .dflag_n  (dflag_n)
   );

   assign count_q  = cnt_m;
   assign snap_q   = snap_r & mask;
   assign preset_q = lim;

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_enable && !do_clr && !do_ld) |=> $stable(cnt_r));  // R2

   AST_SINGLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CM_SINGLE) && stop_r && !do_clr && !do_ld) |=> $stable(cnt_r));  // R5

   AST_RANGE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && (mode == CM_RANGE) && cnt_up && (cnt_m == lim)) |=> $stable(cnt_r));  // R6

   AST_MODN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && (mode == CM_MODN) && cnt_up && (cnt_m == lim)) |=> (cnt_r == '0));  // R7

endmodule

// File: tb/test_enc_pos_counter.sv
module test_enc_pos_counter;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_pulse = 1'b0, cnt_up = 1'b0, cnt_enable = 1'b0, index_stb = 1'b0;
   logic         sw_clear = 1'b0, sw_load = 1'b0, sw_snap = 1'b0, stat_clear = 1'b0;
   logic         cfg_a_wr = 1'b0, cfg_b_wr = 1'b0, preset_wr = 1'b0;
   logic [7:0]   cfg_wdata = '0;
   logic [W-1:0] preset_wdata = '0;
   logic [W-1:0] count_q, snap_q, preset_q;
   logic [7:0]   status_q;
   logic         lflag_n, dflag_n;

   enc_pos_counter #(.BYTES(4)) i_enc_pos_counter (
      .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
      .cnt_enable(cnt_enable), .index_stb(index_stb), .sw_clear(sw_clear),
      .sw_load(sw_load), .sw_snap(sw_snap), .stat_clear(stat_clear),
      .cfg_a_wr(cfg_a_wr), .cfg_b_wr(cfg_b_wr), .cfg_wdata(cfg_wdata),
      .preset_wr(preset_wr), .preset_wdata(preset_wdata), .count_q(count_q),
      .snap_q(snap_q), .preset_q(preset_q), .status_q(status_q),
      .lflag_n(lflag_n), .dflag_n(dflag_n)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] m_cnt = '0, m_dtr = '0, m_snap = '0;
   logic [3:0]   m_a = '0;
   logic [7:0]   m_b = '0;
   bit m_stop = 0;
   bit l_cy = 0, l_bw = 0, l_cmp = 0, l_idx = 0, l_pls = 1, l_dir = 0, l_sgn = 0;

   function automatic logic [W-1:0] wmask(input logic [1:0] w);
      case (w)
         2'b00:   return 32'hFFFF_FFFF;
         2'b01:   return 32'h00FF_FFFF;
         2'b10:   return 32'h0000_FFFF;
         default: return 32'h0000_00FF;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic wr_a(input logic [3:0] v);
      cfg_a_wr = 1'b1; cfg_wdata = {4'h0, v};
      @(posedge clk); #1;
      cfg_a_wr = 1'b0;
      m_a = v;
   endtask

   task automatic wr_b(input logic [7:0] v);
      cfg_b_wr = 1'b1; cfg_wdata = v;
      @(posedge clk); #1;
      cfg_b_wr = 1'b0;
      m_b = v;
   endtask

   task automatic wr_d(input logic [W-1:0] v);
      preset_wr = 1'b1; preset_wdata = v;
      @(posedge clk); #1;
      preset_wr = 1'b0;
      m_dtr = v;
      chk("R3", "preset_q", preset_q, v & wmask(m_b[1:0]));
   endtask

   task automatic cyc(input string tag, input bit pulse, input bit up, input bit idx,
                      input bit clr, input bit ld, input bit snap, input bit sclr);
      logic [W-1:0] mk, lim, nxt;
      bit en, dclr, dld, dsnap, ev, cy, bw, cmp, dyn;
      cnt_pulse = pulse; cnt_up = up; index_stb = idx;
      sw_clear = clr; sw_load = ld; sw_snap = snap; stat_clear = sclr;
      @(posedge clk); #1;
      cnt_pulse = 1'b0; index_stb = 1'b0; sw_clear = 1'b0;
      sw_load = 1'b0; sw_snap = 1'b0; stat_clear = 1'b0;
      mk    = wmask(m_b[1:0]);
      lim   = m_dtr & mk;
      en    = cnt_enable && !m_b[2];
      dclr  = clr || (idx && m_a[3:2] == 2'b10);
      dld   = !dclr && (ld || (idx && m_a[3:2] == 2'b01));
      dsnap = snap || (idx && m_a[3:2] == 2'b11);
      ev    = pulse && en && !(m_a[1:0] == 2'b01 && m_stop) && !dclr && !dld;
      cy = 0; bw = 0; cmp = 0; nxt = m_cnt;
      if (ev) begin
         case (m_a[1:0])
            2'b10: begin
               if (up) begin if (m_cnt == lim) cy = 1; else nxt = (m_cnt + 1) & mk; end
               else    begin if (m_cnt == 0)   bw = 1; else nxt = m_cnt - 1; end
            end
            2'b11: begin
               if (up) begin if (m_cnt == lim) begin nxt = 0; cy = 1; end else nxt = (m_cnt + 1) & mk; end
               else    begin if (m_cnt == 0) begin nxt = lim; bw = 1; end else nxt = m_cnt - 1; end
            end
            default: begin
               if (up) begin if (m_cnt == mk) begin nxt = 0; cy = 1; end else nxt = m_cnt + 1; end
               else    begin if (m_cnt == 0) begin nxt = mk; bw = 1; end else nxt = m_cnt - 1; end
            end
         endcase
         cmp = (nxt == lim);
      end
      if (dsnap) m_snap = m_cnt & mk;
      if (dclr)      m_cnt = 0;
      else if (dld)  m_cnt = lim;
      else if (ev)   m_cnt = nxt;
      if (dclr || dld) m_stop = 0;
      else if (m_a[1:0] == 2'b01 && (cy || bw)) m_stop = 1;
      if (sclr) begin l_cy = 0; l_bw = 0; l_cmp = 0; l_idx = 0; l_pls = 0; l_sgn = 0; if (!ev) l_dir = 0; end
      l_cy  = l_cy | cy;
      l_bw  = l_bw | bw;
      l_cmp = l_cmp | cmp;
      l_idx = l_idx | idx;
      if (ev) l_dir = up;
      l_sgn = l_sgn ^ (cy | bw);
      case (m_a[1:0])
         2'b00:   dyn = |({cy, bw, cmp, idx} & m_b[7:4]);
         2'b01:   dyn = cy | bw;
         default: dyn = (cmp & up) | bw;
      endcase
      chk(tag, "count_q", count_q, m_cnt & mk);
      chk(tag, "snap_q", snap_q, m_snap & mk);
      chk(tag, "status_q", {24'h0, status_q}, {24'h0, l_cy, l_bw, l_cmp, l_idx, en, l_pls, l_dir, l_sgn});
      chk(tag, "lflag_n", {31'h0, lflag_n}, {31'h0, ~|({l_cy, l_bw, l_cmp, l_idx} & m_b[7:4])});
      chk(tag, "dflag_n", {31'h0, dflag_n}, {31'h0, ~dyn});
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values
      chk("R1", "count_q", count_q, 0);
      chk("R1", "preset_q", preset_q, 0);
      chk("R1", "snap_q", snap_q, 0);
      chk("R1", "status_q", {24'h0, status_q}, 32'h04);
      chk("R1", "lflag_n", {31'h0, lflag_n}, 1);
      chk("R1", "dflag_n", {31'h0, dflag_n}, 1);
      cyc("R1", 1, 1, 0, 0, 0, 0, 0);
      cnt_enable = 1'b1;
      cyc("R1", 1, 1, 0, 0, 0, 0, 0);
      cyc("R1", 1, 0, 0, 0, 0, 0, 0);
      cyc("R4", 1, 0, 0, 0, 0, 0, 0);

      // R3, R4: one-byte width, free-running wrap both ways
      wr_b(8'h03);
      cyc("R3", 0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 260; i++) cyc("R4", 1, 1, 0, 0, 0, 0, 0);
      cyc("R10", 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 6; i++) cyc("R4", 1, 0, 0, 0, 0, 0, 0);

      // R2: enable pin and disable bit
      cnt_enable = 1'b0;
      cyc("R2", 1, 1, 0, 0, 0, 0, 0);
      cnt_enable = 1'b1;
      wr_b(8'h07);
      cyc("R2", 1, 1, 0, 0, 0, 0, 0);
      wr_b(8'h03);
      cyc("R2", 1, 1, 0, 0, 0, 0, 0);

      // R11: latched flag
      wr_b(8'hF3);
      wr_d(32'h5);
      cyc("R11", 0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 8; i++) cyc("R11", 1, 1, 0, 0, 0, 0, 0);
      cyc("R11", 0, 0, 0, 0, 0, 0, 0);
      cyc("R11", 0, 0, 0, 0, 0, 0, 1);

      // R5: single-cycle
      wr_a(4'h1);
      cyc("R5", 0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 3; i++) cyc("R5", 1, 0, 0, 0, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 2; i++) cyc("R5", 1, 1, 0, 0, 0, 0, 0);

      // R6: range-limit
      wr_a(4'h2);
      wr_d(32'd10);
      cyc("R6", 0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 14; i++) cyc("R6", 1, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 13; i++) cyc("R6", 1, 0, 0, 0, 0, 0, 0);

      // R7: modulo-n
      wr_a(4'h3);
      wr_d(32'd6);
      cyc("R7", 0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 16; i++) cyc("R7", 1, 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 16; i++) cyc("R7", 1, 0, 0, 0, 0, 0, 0);

      // R8: index actions
      wr_a(4'h4);
      wr_d(32'h33);
      cyc("R8", 0, 0, 1, 0, 0, 0, 1);
      cyc("R8", 1, 1, 0, 0, 0, 0, 0);
      wr_a(4'hC);
      cyc("R8", 0, 0, 1, 0, 0, 0, 0);
      wr_a(4'h8);
      cyc("R8", 0, 0, 1, 0, 0, 0, 0);
      wr_a(4'h0);
      cyc("R8", 0, 0, 0, 0, 0, 0, 1);
      cyc("R8", 0, 0, 1, 0, 0, 0, 0);

      // R9: strobe priority
      cyc("R9", 1, 1, 0, 0, 0, 0, 1);
      cyc("R9", 1, 1, 0, 1, 1, 0, 0);
      cyc("R9", 1, 1, 0, 0, 1, 0, 0);
      cyc("R9", 1, 1, 0, 0, 0, 1, 0);

      // R3: wider widths
      wr_b(8'h02);
      cyc("R3", 0, 0, 0, 1, 0, 0, 1);
      cyc("R3", 1, 0, 0, 0, 0, 0, 0);
      wr_b(8'h01);
      cyc("R3", 0, 0, 0, 1, 0, 0, 1);
      cyc("R3", 1, 0, 0, 0, 0, 0, 0);
      wr_b(8'h00);
      wr_d(32'hFFFF_FFFF);
      cyc("R3", 0, 0, 0, 0, 1, 0, 1);
      cyc("R3", 1, 1, 0, 0, 0, 0, 0);

      // R12 and R10: sweep every mode over several presets at one byte
      for (int md = 0; md < 4; md++) begin
         for (int k = 0; k < 3; k++) begin
            logic [W-1:0] dv;
            dv = (k == 0) ? 32'd0 : (k == 1) ? 32'd3 : 32'd255;
            wr_b(8'hF3);
            wr_a(4'(md));
            wr_d(dv);
            cyc("R12", 0, 0, 0, 1, 0, 0, 1);
            for (int i = 0; i < 300; i++)
               cyc("R12", 1, (i < 150) || (i % 7 == 0), (i % 37 == 5), 0, 0, 0, (i % 61 == 60));
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule